// File: doc/BRIEF.md
# Hiccup Overload Protection Controller

This block decides when a step-down converter's power stage must stop switching because of a sustained overload. Once per switching period a strobe arrives together with two flags from the current-limit comparators: one raised when the low-side switch current was above its valley limit, one raised when the high-side limit cut the on-time short. The block integrates only the low-side flag in a saturating up/down counter. A brief overload therefore decays away. A persistent one drives the counter to its top value, and at that point the block tri-states the power stage.

In the protective wait the block counts switching strobes for three soft-start durations. It then releases the power stage and fires a one-clock restart pulse for the soft-start generator. The integrator stays armed during the soft-start ramp, so a converter that starts into a short trips again without finishing its ramp. Deasserting the enable input drops the block to an idle state with the switches off.

The soft-start duration is a parameter expressed in switching strobes. The counter width is also a parameter. The state is reported on a 2-bit indicator with this encoding: 0 idle, 1 run, 2 wait, 3 soft-start.

Top module: `hiccup_guard`

## Requirements
- R1: While reset is held and in the clock after its release, state_o is 0 (idle), pwr_hiz is 1 and ss_start is 0.
- R2: From idle, a clock with en high moves state_o to 3 (soft-start) at that edge. At the same edge pwr_hiz falls to 0 and ss_start is 1 for exactly one clock.
- R3: In soft-start, a clock with ss_done high and no trip moves state_o to 1 (run). pwr_hiz stays 0.
- R4: In soft-start or run, each strobe with ls_lim high adds one to the integrator. Each strobe with ls_lim low subtracts one. Clocks without a strobe leave it unchanged.
- R5: The integrator never goes below zero. Clean strobes at zero keep it at zero, so after any run of clean strobes, 15 consecutive event strobes are needed to trip (default 4-bit width).
- R6: hs_lim has no effect on the integrator or on the state.
- R7: The strobe that brings the integrator to its maximum (15 by default) moves state_o to 2 (wait) at that edge. At the same edge pwr_hiz rises to 1 and the integrator clears.
- R8: The wait lasts exactly 3 × SS_STROBES strobes. The edge of the last of those strobes moves state_o to 3 with a one-clock ss_start pulse and pwr_hiz at 0.
- R9: Detection is active during soft-start. A trip on the same clock as ss_done wins and enters the wait.
- R10: A clock with en low moves the block to idle (state_o 0, pwr_hiz 1) and clears the integrator. After re-enable, 15 fresh events are needed to trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Enables power delivery control |
| cyc_stb | input | 1 | One-clock strobe per switching period |
| ls_lim | input | 1 | Low-side current limit hit in this period (valid with strobe) |
| hs_lim | input | 1 | High-side current limit hit in this period (ignored) |
| ss_done | input | 1 | Soft-start ramp has completed |
| pwr_hiz | output | 1 | Command to tri-state both power switches |
| ss_start | output | 1 | One-clock pulse that starts a soft-start ramp |
| state_o | output | 2 | Controller state: 0 idle, 1 run, 2 wait, 3 soft-start |

## Verification
The bench targets the integrator's floor. If the counter wrapped below zero, a single clean strobe at zero would trip the block at once. It therefore checks that exactly fourteen events after a run of clean strobes leave the block running and that the fifteenth trips it. It counts the wait length in strobes with gaps between them, which exposes a timer that is off by one or that counts clocks instead of strobes. It drives a trip together with ss_done during soft-start, which a design that treated the ramp as exempt from detection would mishandle. It also floods hs_lim and re-enables after a disable, to catch a design that counts high-side hits or keeps a stale count across the idle state.

// File: rtl/hg_pkg.sv
// Shared types for the hiccup overload protection controller.
package hg_pkg;
    typedef enum logic [1:0] {
        HG_IDLE    = 2'd0,
        HG_RUN     = 2'd1,
        HG_WAIT    = 2'd2,
        HG_RESTART = 2'd3
    } hg_state_e;
endpackage

// File: rtl/hg_event_integ.sv
// Saturating up/down integrator of low-side limit events.
// Assumes: stb is one clock wide; evt is valid while stb is high.
// Counts only while active is high and clears whenever it is low. Raises trip
// combinationally on the strobe that would bring the count to its maximum, and
// clears the count at that edge.
module hg_event_integ #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic stb,
    input  logic evt,
    output logic trip
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;

    // Saturating next value: step up on an event, step down otherwise.
    always_comb begin
        cnt_nxt = cnt;
        if (evt) begin
            if (cnt != CNT_MAX) cnt_nxt = cnt + 1'b1;
        end else if (cnt != '0) begin
            cnt_nxt = cnt - 1'b1;
        end
    end

    assign trip = active && stb && evt && (cnt_nxt == CNT_MAX);

    // Count register: cleared when inactive or on trip, advanced per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || trip) cnt <= '0;
        else if (stb)                  cnt <= cnt_nxt;
    end
endmodule

// File: rtl/hg_wait_timer.sv
// Counts switching strobes during the protective wait.
// Assumes: run stays high for the whole wait; the count restarts whenever
// run is low. done is raised combinationally on the LEN-th strobe.
module hg_wait_timer #(
    parameter int LEN = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic stb,
    output logic done
);
    localparam int TW = $clog2(LEN + 1);
    localparam logic [TW-1:0] LAST = TW'(LEN - 1);

    logic [TW-1:0] wcnt;

    assign done = run && stb && (wcnt == LAST);

    // Strobe counter: held at zero outside the wait, restarts after done.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || done) wcnt <= '0;
        else if (stb)               wcnt <= wcnt + 1'b1;
    end
endmodule

// File: rtl/hg_fsm.sv
// Sequencing of idle, soft-start, run and wait phases.
// Assumes: trip and done are one-clock qualifiers from the integrator and the
// wait timer. Outputs are registered and change at the same edge as state.
module hg_fsm
    import hg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      trip,
    input  logic      done,
    input  logic      ss_done,
    output hg_state_e state,
    output logic      active,
    output logic      pwr_hiz,
    output logic      ss_start
);
    hg_state_e nxt;

    // Next-state decision; disable overrides every other condition.
    always_comb begin
        nxt = state;
        if (!en) begin
            nxt = HG_IDLE;
        end else begin
            case (state)
                HG_IDLE:    nxt = HG_RESTART;
                HG_RESTART: if (trip) nxt = HG_WAIT; else if (ss_done) nxt = HG_RUN;
                HG_RUN:     if (trip) nxt = HG_WAIT;
                HG_WAIT:    if (done) nxt = HG_RESTART;
                default:    nxt = HG_IDLE;
            endcase
        end
    end

    assign active = en && (state == HG_RUN || state == HG_RESTART);

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= HG_IDLE;
            pwr_hiz  <= 1'b1;
            ss_start <= 1'b0;
        end else begin
            state    <= nxt;
            pwr_hiz  <= !(nxt == HG_RUN || nxt == HG_RESTART);
            ss_start <= (nxt == HG_RESTART) && (state != HG_RESTART);
        end
    end
endmodule

// File: rtl/hiccup_guard.sv
// Top of the hiccup overload protection controller.
// Assumes: cyc_stb marks each switching period for one clock and the limit
// flags are valid with it. The wait lasts WAIT_MULT soft-start durations, with
// SS_STROBES the soft-start duration in strobes.
module hiccup_guard
    import hg_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int SS_STROBES  = 8,
    parameter int WAIT_MULT   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       cyc_stb,
    input  logic       ls_lim,
    input  logic       hs_lim,
    input  logic       ss_done,
    output logic       pwr_hiz,
    output logic       ss_start,
    output logic [1:0] state_o
);
    localparam int WAIT_LEN = WAIT_MULT * SS_STROBES;

    hg_state_e state;
    logic      active;
    logic      trip;
    logic      done;
    logic      hs_unused;

    assign hs_unused = hs_lim;

    hg_event_integ #(.CNT_W(CNT_W)) u_integ (
        .clk(clk), .rst_n(rst_n), .active(active),
        .stb(cyc_stb), .evt(ls_lim), .trip(trip)
    );

    hg_wait_timer #(.LEN(WAIT_LEN)) u_wait (
        .clk(clk), .rst_n(rst_n), .run(state == HG_WAIT),
        .stb(cyc_stb), .done(done)
    );

    hg_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .trip(trip), .done(done),
        .ss_done(ss_done), .state(state), .active(active),
        .pwr_hiz(pwr_hiz), .ss_start(ss_start)
    );

    assign state_o = state;
endmodule

// File: rtl/hiccup_guard_chk.sv
// Property checker for hiccup_guard, attached with bind.
module hiccup_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       cyc_stb,
    input logic       ls_lim,
    input logic       hs_lim,
    input logic       pwr_hiz,
    input logic       ss_start,
    input logic [1:0] state_o
);
    AST_START_IN_SS: assert property (@(posedge clk) disable iff (!rst_n)
        ss_start |-> (state_o == 2'd3 && !pwr_hiz)); // R2
    AST_START_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        ss_start |=> !ss_start); // R2
    AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0 && en) |=> (state_o == 2'd3 && ss_start)); // R2
    AST_NO_STB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1 && en && !cyc_stb) |=> state_o == 2'd1); // R4
    AST_CLEAN_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1 && en && cyc_stb && !ls_lim && (hs_lim || !hs_lim)) |=> state_o == 2'd1); // R6
    AST_WAIT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2 || state_o == 2'd0) |-> pwr_hiz); // R7
    AST_WAIT_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2 && en && !cyc_stb) |=> state_o == 2'd2); // R8
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_o == 2'd0 && pwr_hiz)); // R10
endmodule

bind hiccup_guard hiccup_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .cyc_stb(cyc_stb), .ls_lim(ls_lim),
    .hs_lim(hs_lim), .pwr_hiz(pwr_hiz), .ss_start(ss_start), .state_o(state_o)
);

// File: tb/sim_hiccup_guard.sv
module sim_hiccup_guard;
    localparam int CLK_PERIOD = 10;
    localparam int SS         = 5;
    localparam int WAIT_LEN   = 3 * SS;
    localparam int CMAX       = 15;

    logic clk = 1'b0, rst_n = 1'b0;
    logic en = 1'b0, cyc_stb = 1'b0, ls_lim = 1'b0, hs_lim = 1'b0, ss_done = 1'b0;
    logic pwr_hiz, ss_start;
    logic [1:0] state_o;

    int n_run = 0, n_fail = 0;
    int unsigned seed = 32'h00C0FFEE;

    // Reference model state, derived from the requirements.
    int m_st = 0, m_cnt = 0, m_wc = 0;
    logic m_hiz = 1'b1, m_ss = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hiccup_guard #(.SS_STROBES(SS)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .cyc_stb(cyc_stb), .ls_lim(ls_lim),
        .hs_lim(hs_lim), .ss_done(ss_done), .pwr_hiz(pwr_hiz),
        .ss_start(ss_start), .state_o(state_o)
    );

    // Model step at each edge using the inputs held since the last negedge.
    always @(posedge clk) begin
        m_ss = 1'b0;
        if (!rst_n || !en) begin
            m_st = 0; m_cnt = 0; m_wc = 0; m_hiz = 1'b1;
        end else if (m_st == 0) begin
            m_st = 3; m_ss = 1'b1; m_hiz = 1'b0;
        end else if (m_st == 1 || m_st == 3) begin
            logic tr;
            tr = 1'b0;
            if (cyc_stb) begin
                if (ls_lim) begin
                    if (m_cnt == CMAX - 1) tr = 1'b1; else m_cnt = m_cnt + 1;
                end else if (m_cnt > 0) m_cnt = m_cnt - 1;
            end
            if (tr) begin
                m_st = 2; m_cnt = 0; m_wc = 0; m_hiz = 1'b1;
            end else if (m_st == 3 && ss_done) m_st = 1;
        end else if (cyc_stb) begin
            m_wc = m_wc + 1;
            if (m_wc == WAIT_LEN) begin
                m_st = 3; m_ss = 1'b1; m_hiz = 1'b0; m_wc = 0;
            end
        end
    end

    function automatic void chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endfunction

    // Compare all outputs to the model.
    task automatic cmp_model();
        chk(state_o == 2'(m_st), "R4 state", state_o, m_st);
        chk(pwr_hiz == m_hiz, "R7 pwr_hiz", pwr_hiz, m_hiz);
        chk(ss_start == m_ss, "R2 ss_start", ss_start, m_ss);
    endtask

    // One clock: drive at negedge, sample just after the edge.
    task automatic cyc(input logic e, input logic s, input logic l, input logic h, input logic d);
        @(negedge clk);
        en = e; cyc_stb = s; ls_lim = l; hs_lim = h; ss_done = d;
        @(posedge clk); #1;
        cmp_model();
    endtask

    task automatic to_run();
        cyc(1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) begin @(posedge clk); #1; end
        chk(state_o == 2'd0 && pwr_hiz && !ss_start, "R1 reset", state_o, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(state_o == 2'd0 && pwr_hiz, "R1 after release", state_o, 0);

        // R2: enable from idle
        cyc(1, 0, 0, 0, 0);
        chk(state_o == 2'd3 && ss_start && !pwr_hiz, "R2 enter soft-start", state_o, 3);
        cyc(1, 0, 0, 0, 0);
        chk(!ss_start, "R2 pulse width", ss_start, 0);
        // R3: soft-start done
        cyc(1, 0, 0, 0, 1);
        chk(state_o == 2'd1 && !pwr_hiz, "R3 to run", state_o, 1);

        // R5: clean strobes at zero, then 14 events plus hs flood (R6)
        for (int i = 0; i < 6; i++) cyc(1, 1, 0, 1, 0);
        chk(state_o == 2'd1, "R5 floor no trip", state_o, 1);
        for (int i = 0; i < CMAX - 1; i++) begin
            cyc(1, 1, 1, 1, 0);
            cyc(1, 0, 0, 1, 0);
        end
        chk(state_o == 2'd1, "R6 fourteen events with hs flood", state_o, 1);
        cyc(1, 1, 1, 0, 0);
        chk(state_o == 2'd2 && pwr_hiz, "R7 trip on fifteenth", state_o, 2);

        // R8: wait length in strobes, strobes with gaps
        begin
            int ns;
            ns = 0;
            while (state_o == 2'd2 && ns < 4 * WAIT_LEN) begin
                cyc(1, 1, 1, 0, 0); ns++;
                if (state_o == 2'd2) cyc(1, 0, 0, 0, 0);
            end
            chk(ns == WAIT_LEN, "R8 wait strobes", ns, WAIT_LEN);
            chk(state_o == 2'd3 && ss_start && !pwr_hiz, "R8 retry", state_o, 3);
        end

        // R9: trip during soft-start, coincident with ss_done
        for (int i = 0; i < CMAX - 1; i++) cyc(1, 1, 1, 0, 0);
        chk(state_o == 2'd3, "R9 still ramping", state_o, 3);
        cyc(1, 1, 1, 0, 1);
        chk(state_o == 2'd2, "R9 trip beats ss_done", state_o, 2);

        // R10: disable mid-wait, then counter starts fresh
        cyc(0, 1, 0, 0, 0);
        chk(state_o == 2'd0 && pwr_hiz, "R10 idle on disable", state_o, 0);
        to_run();
        for (int i = 0; i < CMAX - 2; i++) cyc(1, 1, 1, 0, 0);
        cyc(0, 0, 0, 0, 0);
        to_run();
        for (int i = 0; i < CMAX - 1; i++) cyc(1, 1, 1, 0, 0);
        chk(state_o == 2'd1, "R10 count cleared by disable", state_o, 1);
        cyc(1, 1, 1, 0, 0);
        chk(state_o == 2'd2, "R10 fresh trip", state_o, 2);

        // R4: random traffic against the model, varying overload density
        for (int blk = 0; blk < 30; blk++) begin
            int p;
            p = (blk % 3 == 0) ? 15 : ((blk % 3 == 1) ? 50 : 90);
            for (int i = 0; i < 100; i++) begin
                logic e, s, l, h, d;
                e = ($urandom(seed) % 300) != 0;
                s = ($urandom(seed) % 3) == 0;
                l = ($urandom(seed) % 100) < p;
                h = $urandom(seed) % 2;
                d = ($urandom(seed) % 20) == 0;
                cyc(e, s, l, h, d);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule